// File: doc/BRIEF.md
# Monochrome display command/data decoder

This block turns a byte stream from a serial target front end into framebuffer writes and display settings for a paged monochrome panel. Each byte arrives with a one-cycle valid strobe. A separate one-cycle pulse marks the end of a transaction. While the decoder is waiting, the next byte must be a control byte. Control byte 0x80 selects command interpretation and 0x40 selects pixel data. Data bytes go out on a write port to a framebuffer of 8 pages by 132 byte columns. Command bytes move the column and page pointers and set four display flags: enable, inverse, all-on and mirror.

The mode machine has four named states. In ST_IDLE the decoder waits for a control byte. In ST_DATA it streams pixel bytes. In ST_CMD it interprets one opcode. In ST_PARAM it discards one parameter byte. The transitions are:
- ST_IDLE to ST_CMD on 0x80, and ST_IDLE to ST_DATA on 0x40.
- ST_DATA holds on every byte.
- ST_CMD goes to ST_PARAM on a parameter-taking opcode and to ST_IDLE on any other opcode.
- ST_PARAM goes back to ST_CMD on the next byte.
- A transaction end forces any state to ST_IDLE.

The scan-out side reads the framebuffer and the flags. It clears the redraw flag with a pulse once it has refreshed the panel.

Top module: `mono_panel_decoder`

## Requirements
- R1: In ST_IDLE, a byte other than 0x80 or 0x40 pulses `ctrl_err` high for the one cycle after it is taken. The state stays ST_IDLE, and nothing else changes.
- R2: In ST_DATA, a byte taken while `col_ptr` < 132 appears on the write port in the next cycle. In that cycle `fb_we`=1, `fb_addr` = `col_ptr` + 132*`page_ptr`, and `fb_wdata` = the byte. When `col_ptr` ≥ 132 the byte is dropped, with no write.
- R3: Each accepted data write increments `col_ptr` by one. A command opcode 0x00–0x0F loads `col_ptr[3:0]` from opcode bits [3:0]. An opcode 0x10–0x20 loads `col_ptr[7:4]` from opcode bits [3:0].
- R4: Opcodes 0xB0–0xBF set `page_ptr` to opcode bits [2:0].
- R5: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB move to ST_PARAM. The next byte is discarded with no effect, and the state then returns to ST_CMD, so the byte after that is read as an opcode.
- R6: Opcode bit 0 sets the flag for each pair: 0xA0/0xA1 for `disp_mirror`, 0xA4/0xA5 for `disp_allon`, 0xA6/0xA7 for `disp_inv`, and 0xAE/0xAF for `disp_en`.
- R7: Opcodes 0x40–0x7F, 0xC0–0xC8 and 0xE3 are accepted with no visible effect. Every opcode not listed in R3–R7 pulses `unk_cmd` for one cycle and changes nothing else.
- R8: After any opcode that does not move to ST_PARAM, the state returns to ST_IDLE, so the next byte is again a control byte. A `xfer_end` pulse forces ST_IDLE, even when a byte is taken in the same cycle.
- R9: An accepted data write sets `redraw`. A `redraw_clr` pulse clears it. If both happen in the same cycle, the write wins.
- R10: A synchronous reset gives ST_IDLE, `col_ptr`=0, `page_ptr`=0, all flags 0, and no write, error or unknown pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe for `byte_data` |
| byte_data | input | 8 | Received byte |
| xfer_end | input | 1 | Transaction-end pulse |
| redraw_clr | input | 1 | Scan-out clears the redraw flag |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| col_ptr | output | 8 | Column pointer |
| page_ptr | output | 3 | Page pointer |
| disp_en | output | 1 | Display enable flag |
| disp_inv | output | 1 | Inverse video flag |
| disp_allon | output | 1 | All pixels lit flag |
| disp_mirror | output | 1 | Horizontal mirror flag |
| redraw | output | 1 | Framebuffer changed since last clear |
| ctrl_err | output | 1 | Pulse: bad control byte |
| unk_cmd | output | 1 | Pulse: unknown opcode |

## Verification
The assertions assume that `byte_valid`, `xfer_end` and `redraw_clr` are clean single-cycle-or-longer levels, and that nothing is known about them during reset. They also assume that the data path never sees a page pointer outside the framebuffer, so the write address stays in range. The stimulus drives each byte for exactly one cycle at the falling edge and asserts reset before every opcode in the 256-value sweep. It combines `xfer_end` and `redraw_clr` with bytes only in the deliberate same-cycle cases called out by R8 and R9.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CMD,
        ST_PARAM
    } mode_e;

    typedef enum logic [3:0] {
        OP_COL_LO,
        OP_COL_HI,
        OP_PAGE,
        OP_SKIP,
        OP_MIRROR,
        OP_ALLON,
        OP_INVERT,
        OP_ENABLE,
        OP_NOP,
        OP_UNKNOWN
    } op_e;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;

endpackage

// File: rtl/mpd_opcode_decode.sv
module mpd_opcode_decode
    import mpd_pkg::*;
(
    input  logic [7:0] opcode,
    output op_e        kind
);

    always_comb begin
        if (opcode <= 8'h0F)
            kind = OP_COL_LO;
        else if (opcode <= 8'h20)
            kind = OP_COL_HI;
        else if (opcode >= 8'h40 && opcode <= 8'h7F)
            kind = OP_NOP;
        else if (opcode >= 8'hB0 && opcode <= 8'hBF)
            kind = OP_PAGE;
        else if (opcode >= 8'hC0 && opcode <= 8'hC8)
            kind = OP_NOP;
        else begin
            case (opcode)
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB:   kind = OP_SKIP;
                8'hA0, 8'hA1:                 kind = OP_MIRROR;
                8'hA4, 8'hA5:                 kind = OP_ALLON;
                8'hA6, 8'hA7:                 kind = OP_INVERT;
                8'hAE, 8'hAF:                 kind = OP_ENABLE;
                8'hE3:                        kind = OP_NOP;
                default:                      kind = OP_UNKNOWN;
            endcase
        end
    end

endmodule

// File: rtl/mpd_mode_fsm.sv
module mpd_mode_fsm
    import mpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       xfer_end,
    input  op_e        op_kind,
    output mode_e      mode,
    output logic       data_take,
    output logic       cmd_take,
    output logic       ctrl_err
);

    mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (byte_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (byte_data == CTRL_CMD)       state_d = ST_CMD;
                    else if (byte_data == CTRL_DATA) state_d = ST_DATA;
                end
                ST_DATA:  state_d = ST_DATA;
                ST_CMD:   state_d = (op_kind == OP_SKIP) ? ST_PARAM : ST_IDLE;
                ST_PARAM: state_d = ST_CMD;
            endcase
        end
        if (xfer_end) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        mode      = state_q;
        data_take = byte_valid && (state_q == ST_DATA);
        cmd_take  = byte_valid && (state_q == ST_CMD);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_err <= 1'b0;
        else
            ctrl_err <= byte_valid && (state_q == ST_IDLE) &&
                        (byte_data != CTRL_CMD) && (byte_data != CTRL_DATA);
    end

    a_r1_err_stays_idle: assert property (@(posedge clk) disable iff (rst)
        ctrl_err |-> (state_q == ST_IDLE));

    a_r8_end_forces_idle: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> (state_q == ST_IDLE));

    a_r5_param_returns: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARAM && byte_valid && !xfer_end) |=> (state_q == ST_CMD));

endmodule

// File: rtl/mpd_wr_port.sv
module mpd_wr_port #(
    parameter int COLS  = 132,
    parameter int PAGES = 8,
    parameter int AW    = 11,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [7:0]    col,
    input  logic [PW-1:0] page,
    input  logic [7:0]    wdata,
    output logic          accept,
    output logic          fb_we,
    output logic [AW-1:0] fb_addr,
    output logic [7:0]    fb_wdata
);

    localparam int DEPTH = COLS * PAGES;

    logic [AW-1:0] addr_d;

    always_comb begin
        accept = take && (int'(col) < COLS);
        addr_d = AW'(page) * AW'(COLS) + AW'(col);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_we    <= 1'b0;
            fb_addr  <= '0;
            fb_wdata <= '0;
        end else begin
            fb_we <= accept;
            if (accept) begin
                fb_addr  <= addr_d;
                fb_wdata <= wdata;
            end
        end
    end

    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (int'(fb_addr) < DEPTH));

endmodule

// File: rtl/mono_panel_decoder.sv
module mono_panel_decoder
    import mpd_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8,
    localparam int AW   = $clog2(COLS * PAGES),
    localparam int PW   = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          xfer_end,
    input  logic          redraw_clr,
    output logic          fb_we,
    output logic [AW-1:0] fb_addr,
    output logic [7:0]    fb_wdata,
    output logic [7:0]    col_ptr,
    output logic [PW-1:0] page_ptr,
    output logic          disp_en,
    output logic          disp_inv,
    output logic          disp_allon,
    output logic          disp_mirror,
    output logic          redraw,
    output logic          ctrl_err,
    output logic          unk_cmd
);

    op_e   op_kind;
    mode_e mode;
    logic  data_take, cmd_take, accept;

    mpd_opcode_decode u_dec (
        .opcode (byte_data),
        .kind   (op_kind)
    );

    mpd_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .xfer_end   (xfer_end),
        .op_kind    (op_kind),
        .mode       (mode),
        .data_take  (data_take),
        .cmd_take   (cmd_take),
        .ctrl_err   (ctrl_err)
    );

    mpd_wr_port #(
        .COLS  (COLS),
        .PAGES (PAGES),
        .AW    (AW),
        .PW    (PW)
    ) u_wr (
        .clk      (clk),
        .rst      (rst),
        .take     (data_take),
        .col      (col_ptr),
        .page     (page_ptr),
        .wdata    (byte_data),
        .accept   (accept),
        .fb_we    (fb_we),
        .fb_addr  (fb_addr),
        .fb_wdata (fb_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            col_ptr     <= '0;
            page_ptr    <= '0;
            disp_en     <= 1'b0;
            disp_inv    <= 1'b0;
            disp_allon  <= 1'b0;
            disp_mirror <= 1'b0;
            unk_cmd     <= 1'b0;
        end else begin
            unk_cmd <= 1'b0;
            if (accept)
                col_ptr <= col_ptr + 8'd1;
            if (cmd_take) begin
                unique case (op_kind)
                    OP_COL_LO:  col_ptr[3:0] <= byte_data[3:0];
                    OP_COL_HI:  col_ptr[7:4] <= byte_data[3:0];
                    OP_PAGE:    page_ptr     <= byte_data[PW-1:0];
                    OP_MIRROR:  disp_mirror  <= byte_data[0];
                    OP_ALLON:   disp_allon   <= byte_data[0];
                    OP_INVERT:  disp_inv     <= byte_data[0];
                    OP_ENABLE:  disp_en      <= byte_data[0];
                    OP_UNKNOWN: unk_cmd      <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             redraw <= 1'b0;
        else if (accept)     redraw <= 1'b1;
        else if (redraw_clr) redraw <= 1'b0;
    end

    a_r3_col_step: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (col_ptr == 8'($past(col_ptr) + 8'd1)));

    a_r9_redraw_on_write: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> redraw);

    a_r2_drop_past_end: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_DATA && byte_valid && int'(col_ptr) >= COLS) |=> !fb_we);

    a_r7_unknown_no_flags: assert property (@(posedge clk) disable iff (rst)
        unk_cmd |-> ($stable(disp_en) && $stable(disp_inv) &&
                     $stable(disp_allon) && $stable(disp_mirror) && $stable(page_ptr)));

endmodule

// File: tb/sim_mono_panel_decoder.sv
module sim_mono_panel_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid, xfer_end, redraw_clr;
    logic [7:0]  byte_data;
    logic        fb_we;
    logic [10:0] fb_addr;
    logic [7:0]  fb_wdata, col_ptr;
    logic [2:0]  page_ptr;
    logic        disp_en, disp_inv, disp_allon, disp_mirror, redraw, ctrl_err, unk_cmd;

    always #4 clk = ~clk;

    mono_panel_decoder u0 (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .xfer_end(xfer_end), .redraw_clr(redraw_clr), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_wdata(fb_wdata), .col_ptr(col_ptr),
        .page_ptr(page_ptr), .disp_en(disp_en), .disp_inv(disp_inv),
        .disp_allon(disp_allon), .disp_mirror(disp_mirror), .redraw(redraw),
        .ctrl_err(ctrl_err), .unk_cmd(unk_cmd)
    );

    int vectors = 0;
    int miscompares = 0;

    // expected state: mode 0 idle, 1 data, 2 command, 3 parameter
    int m_mode, m_col, m_page;
    int m_en, m_inv, m_all, m_mir, m_red;
    int e_we, e_addr, e_data, e_err, e_unk;

    // 0 col lo, 1 col hi, 2 page, 3 param, 4 mirror, 5 all-on, 6 inverse, 7 enable, 8 no-op, 9 unknown
    function automatic int kind_of(int op);
        if (op < 16) return 0;
        if (op <= 32) return 1;
        if (op >= 64 && op < 128) return 8;
        if (op >= 176 && op < 192) return 2;
        if (op >= 192 && op <= 200) return 8;
        if (op == 227) return 8;
        if (op == 129 || op == 168 || op == 173 || op == 211 || op == 213 ||
            (op >= 216 && op <= 219)) return 3;
        if ((op >> 1) == 80) return 4;
        if ((op >> 1) == 82) return 5;
        if ((op >> 1) == 83) return 6;
        if ((op >> 1) == 87) return 7;
        return 9;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 fb_we", fb_we, e_we);
        if (e_we == 1) begin
            chk("R2 fb_addr", fb_addr, e_addr);
            chk("R2 fb_wdata", fb_wdata, e_data);
        end
        chk("R3 col_ptr", col_ptr, m_col);
        chk("R4 page_ptr", page_ptr, m_page);
        chk("R6 disp_en", disp_en, m_en);
        chk("R6 disp_inv", disp_inv, m_inv);
        chk("R6 disp_allon", disp_allon, m_all);
        chk("R6 disp_mirror", disp_mirror, m_mir);
        chk("R9 redraw", redraw, m_red);
        chk("R1 ctrl_err", ctrl_err, e_err);
        chk("R7 unk_cmd", unk_cmd, e_unk);
    endtask

    task automatic model_zero();
        m_mode = 0; m_col = 0; m_page = 0;
        m_en = 0; m_inv = 0; m_all = 0; m_mir = 0; m_red = 0;
        e_we = 0; e_addr = 0; e_data = 0; e_err = 0; e_unk = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; byte_valid = 1'b0; xfer_end = 1'b0; redraw_clr = 1'b0; byte_data = 8'h00;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        model_zero();
    endtask

    task automatic step(int vld, int b, int xe, int clr);
        int k;
        @(negedge clk);
        byte_valid = 1'(vld); byte_data = 8'(b); xfer_end = 1'(xe); redraw_clr = 1'(clr);
        e_we = 0; e_err = 0; e_unk = 0;
        if (clr != 0) m_red = 0;
        if (vld != 0) begin
            case (m_mode)
                0: begin
                    if (b == 128) m_mode = 2;
                    else if (b == 64) m_mode = 1;
                    else e_err = 1;
                end
                1: begin
                    if (m_col < 132) begin
                        e_we = 1; e_addr = m_col + 132 * m_page; e_data = b;
                        m_col = m_col + 1; m_red = 1;
                    end
                end
                2: begin
                    k = kind_of(b);
                    m_mode = (k == 3) ? 3 : 0;
                    case (k)
                        0: m_col = (m_col & 240) | (b & 15);
                        1: m_col = (m_col & 15) | ((b & 15) << 4);
                        2: m_page = b & 7;
                        4: m_mir = b & 1;
                        5: m_all = b & 1;
                        6: m_inv = b & 1;
                        7: m_en = b & 1;
                        9: e_unk = 1;
                        default: ;
                    endcase
                end
                default: m_mode = 2;
            endcase
        end
        if (xe != 0) m_mode = 0;
        @(posedge clk);
        #1;
        compare_all();
        byte_valid = 1'b0; xfer_end = 1'b0; redraw_clr = 1'b0;
    endtask

    task automatic send(int b);
        step(1, b, 0, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; byte_valid = 1'b0; xfer_end = 1'b0; redraw_clr = 1'b0; byte_data = 8'h00;
        do_reset();
        // R10: reset state
        #1;
        chk("R10 col", col_ptr, 0);
        chk("R10 page", page_ptr, 0);
        chk("R10 flags", {disp_en, disp_inv, disp_allon, disp_mirror, redraw}, 0);
        chk("R10 pulses", {fb_we, ctrl_err, unk_cmd}, 0);

        // R1: bad control byte while idle, then a good prefix still works
        send(8'h33);
        send(8'h80);
        send(8'hAF);

        // R3 R4 R5 R6 R7 R8: sweep every opcode after reset
        for (int op = 0; op < 256; op++) begin
            do_reset();
            send(8'h80);
            send(op);
            if (kind_of(op) == 3) begin
                send(8'hAF);   // R5: parameter byte discarded, enable stays 0
                send(8'hA7);   // R5: read as opcode without a prefix
            end else begin
                send(8'hA7);   // R8: back in idle, so this is a bad control byte
            end
        end

        // R2 R3 R4: fill a few columns on every page
        do_reset();
        for (int p = 0; p < 8; p++) begin
            send(8'h80); send(8'hB0 | p);
            send(8'h80); send((p * 7) & 15);
            send(8'h80); send(8'h10 | (((p * 7) >> 4) & 15));
            send(8'h40);
            for (int k = 0; k < 5; k++) send(p * 16 + k);
            step(0, 0, 1, 0);
        end

        // R2: writes past the last column are dropped
        send(8'h80); send(8'h02);
        send(8'h80); send(8'h18);
        send(8'h40);
        for (int k = 0; k < 4; k++) send(8'hC0 + k);
        step(0, 0, 1, 0);
        // R3: opcode 0x20 clears the high nibble
        send(8'h80); send(8'h20);
        send(8'h80); send(8'h1F);
        send(8'h40); send(8'h5A);
        step(0, 0, 1, 0);

        // R9: clear, then simultaneous write and clear
        step(0, 0, 0, 1);
        send(8'h80); send(8'h10);
        send(8'h80); send(8'h00);
        send(8'h40);
        step(1, 8'h77, 0, 1);
        step(0, 0, 0, 1);

        // R8: byte taken with transaction end still leaves idle
        step(1, 8'h40, 1, 0);
        send(8'h55);
        send(8'h40); send(8'h11);
        step(0, 0, 1, 0);
        send(8'h12);

        finish_run();
    end

endmodule